// File: doc/BRIEF.md
# PWM Pulse-Width Distance Meter

This block converts the high time of a range sensor's PWM output into a distance in whole inches. The sensor drives its pin high for 147 µs per inch of measured distance. With a 50 MHz system clock (20 ns period) that works out to 7350 clock cycles per inch. The block counts clock cycles only while the pulse is high. A prescaler wraps once per inch, and each wrap advances an inch counter.

The sensor pin is asynchronous to the system clock. It therefore passes through a cascade of two flip-flops before any logic looks at it, so the counting enable rises and falls in step with the clock. Each rising edge of the synchronized signal starts a new measurement. Each falling edge publishes the truncated inch count on a held output register, raises a one-cycle valid strobe and reports whether the counter saturated. A pulse that is already high when reset is released is discarded.

Top module: `pwm_inch_meter`

## Requirements
- R1: The raw pin passes through two flip-flops before use: when the pin falls before clock edge k, the valid strobe is high during the cycle after edge k+2 and low during the cycles after edges k and k+1.
- R2: If the synchronized pulse is high for H clock edges, the reported count equals floor(H / CYCLES_PER_INCH) when that value does not exceed 2^INCH_W-1.
- R3: `meas_valid` is high for exactly one clock cycle for each completed measurement, and never in any other cycle.
- R4: Each rising edge of the synchronized pulse clears the prescaler and the inch counter, so no result depends on an earlier pulse.
- R5: The inch counter saturates at 2^INCH_W-1. `overflow` is 1 together with that result when at least 2^INCH_W full inches were seen, and otherwise 0. `overflow` updates with every measurement.
- R6: A pulse that is high when reset is released produces no measurement. Counting needs a low-to-high transition seen after reset.
- R7: `inch_out` and `overflow` reset to zero and keep their last values between measurements.
- R8: A partial inch is dropped: a pulse of k*CYCLES_PER_INCH-1 edges reports k-1, and one of k*CYCLES_PER_INCH edges reports k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 50 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_raw | input | 1 | Unsynchronized PWM pin from the range sensor |
| inch_out | output | INCH_W | Distance of the last completed measurement, in whole inches |
| meas_valid | output | 1 | One-cycle strobe when `inch_out` is updated |
| overflow | output | 1 | Set when the last measurement saturated the inch counter |

## Verification
Assertions watch on every cycle that the valid strobe never lasts two cycles and that the prescaler stays inside its range. They also check that the held result and overflow flag change only with a strobe, that the counters stay frozen outside a counted pulse, and that a saturated result always reads full scale. Only the bench scenarios can show the arithmetic and the timing. These are the floor division across inch boundaries, the two-stage latency from pin to strobe, the clearing of stale counts at each new pulse, and the rejection of a pulse already high at reset release.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;
  // Width needed to hold values 0..n-1, at least one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/pwm_edge_arm.sv
module pwm_edge_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic start,
  output logic stop,
  output logic cnt_en
);
  logic prev_q, prev_d;
  logic armed_q, armed_d;
  logic rise;

  always_comb begin
    rise    = lvl & ~prev_q;
    prev_d  = lvl;
    armed_d = armed_q | rise;
    start   = rise;
    stop    = ~lvl & prev_q & armed_q;
    cnt_en  = lvl & armed_d;
  end

  // prev resets high: a pin already high at release does not look like a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  a_r6_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !lvl |-> !stop);
  a_r4_start_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> cnt_en);
endmodule

// File: rtl/pwm_inch_accum.sv
module pwm_inch_accum
  import pwm_meter_pkg::*;
#(
  parameter int unsigned CYCLES_PER_INCH = 7350,
  parameter int unsigned INCH_W          = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cnt_en,
  output logic [INCH_W-1:0] inch,
  output logic              sat
);
  localparam int unsigned PRESC_W = cnt_width(CYCLES_PER_INCH);
  localparam logic [PRESC_W-1:0] P_LAST = PRESC_W'(CYCLES_PER_INCH - 1);
  localparam logic [INCH_W-1:0]  I_MAX  = {INCH_W{1'b1}};

  logic [PRESC_W-1:0] presc_q, presc_d, presc_base;
  logic [INCH_W-1:0]  inch_q, inch_d, inch_base;
  logic               sat_q, sat_d, sat_base;

  always_comb begin
    presc_base = start ? '0 : presc_q;
    inch_base  = start ? '0 : inch_q;
    sat_base   = start ? 1'b0 : sat_q;
    presc_d    = presc_base;
    inch_d     = inch_base;
    sat_d      = sat_base;
    if (cnt_en) begin
      if (presc_base == P_LAST) begin
        presc_d = '0;
        if (inch_base == I_MAX) sat_d  = 1'b1;
        else                    inch_d = inch_base + 1'b1;
      end else begin
        presc_d = presc_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      inch_q  <= '0;
      sat_q   <= 1'b0;
    end else begin
      presc_q <= presc_d;
      inch_q  <= inch_d;
      sat_q   <= sat_d;
    end
  end

  assign inch = inch_q;
  assign sat  = sat_q;

  a_r2_presc_range: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= P_LAST);
  a_r2_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(inch_q) && $stable(presc_q));
  a_r4_start_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> inch_q <= 1 && !sat_q);
  a_r5_sat_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> inch_q == I_MAX);
endmodule

// File: rtl/pwm_inch_meter.sv
module pwm_inch_meter
  import pwm_meter_pkg::*;
#(
  parameter int unsigned CYCLES_PER_INCH = 7350,
  parameter int unsigned INCH_W          = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_raw,
  output logic [INCH_W-1:0] inch_out,
  output logic              meas_valid,
  output logic              overflow
);
  localparam logic [INCH_W-1:0] I_MAX = {INCH_W{1'b1}};

  logic              pwm_lvl;
  logic              start, stop, cnt_en;
  logic [INCH_W-1:0] inch_cnt;
  logic              sat;

  logic [INCH_W-1:0] res_q, res_d;
  logic              ovf_q, ovf_d;
  logic              vld_q, vld_d;

  pwm_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pwm_raw),
    .q_sync  (pwm_lvl)
  );

  pwm_edge_arm u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (pwm_lvl),
    .start  (start),
    .stop   (stop),
    .cnt_en (cnt_en)
  );

  pwm_inch_accum #(
    .CYCLES_PER_INCH (CYCLES_PER_INCH),
    .INCH_W          (INCH_W)
  ) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .cnt_en (cnt_en),
    .inch   (inch_cnt),
    .sat    (sat)
  );

  always_comb begin
    res_d = res_q;
    ovf_d = ovf_q;
    vld_d = stop;
    if (stop) begin
      res_d = inch_cnt;
      ovf_d = sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ovf_q <= ovf_d;
      vld_q <= vld_d;
    end
  end

  assign inch_out   = res_q;
  assign overflow   = ovf_q;
  assign meas_valid = vld_q;

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid);
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |-> $stable(inch_out) && $stable(overflow));
  a_r5_ovf_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> inch_out == I_MAX);
endmodule

// File: tb/pwm_inch_meter_tb.sv
module pwm_inch_meter_tb;
  localparam int unsigned N  = 7;
  localparam int unsigned W  = 4;
  localparam int unsigned MX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pwm_raw;
  logic [W-1:0] inch_out;
  logic         meas_valid;
  logic         overflow;

  int n_chk = 0;
  int n_bad = 0;
  int n_valid = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_inch_meter #(.CYCLES_PER_INCH(N), .INCH_W(W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_raw    (pwm_raw),
    .inch_out   (inch_out),
    .meas_valid (meas_valid),
    .overflow   (overflow)
  );

  always @(posedge clk) if (rst_n && meas_valid) n_valid++;

  function automatic int exp_inch(input int h);
    return (h / N > MX) ? MX : h / N;
  endfunction

  function automatic bit exp_ovf(input int h);
    return (h / N) > MX;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    pwm_raw = pin;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(inch_out == 0, "R7 reset inch", inch_out, 0);
    check(overflow == 0 && meas_valid == 0, "R7 reset flags", {overflow, meas_valid}, 0);
    rst_n = 1'b1;
  endtask

  // Pin high across exactly h clock edges, then low for l (>=4) cycles.
  task automatic pulse(input int h, input int l);
    int ei;
    bit eo;
    logic [W-1:0] held;
    ei = exp_inch(h);
    eo = exp_ovf(h);
    @(negedge clk);
    pwm_raw = 1'b1;
    repeat (h) @(negedge clk);
    pwm_raw = 1'b0;
    @(negedge clk);
    check(!meas_valid, "R1 strobe early (k)", meas_valid, 0);
    @(negedge clk);
    check(!meas_valid, "R1 strobe early (k+1)", meas_valid, 0);
    @(negedge clk);
    check(meas_valid, "R1 strobe at k+2", meas_valid, 1);
    check(inch_out == ei, "R2 R8 inch count", inch_out, ei);
    check(overflow == eo, "R5 overflow flag", overflow, eo);
    held = inch_out;
    @(negedge clk);
    check(!meas_valid, "R3 strobe one cycle", meas_valid, 0);
    repeat (l - 4) @(negedge clk);
    check(inch_out == held && overflow == eo, "R7 hold while idle", inch_out, held);
  endtask

  initial begin
    int base;
    process::self().srandom(32'h5eed_0042);
    rst_n = 1'b0;
    pwm_raw = 1'b0;
    do_reset(1'b0);
    repeat (5) @(negedge clk);

    // Directed corners
    pulse(1, 6);
    pulse(N - 1, 6);          // R8 partial inch dropped
    pulse(N, 6);              // R8 exact inch
    pulse(3 * N - 1, 5);      // R8
    pulse(3 * N, 5);          // R8
    pulse(MX * N, 6);         // R5 full scale, no overflow
    pulse((MX + 1) * N, 6);   // R5 saturation with overflow
    pulse(MX * N + 3 * N, 6); // R5
    pulse(2 * N + 1, 6);      // R4 R5 fresh count, overflow cleared

    // Random pulses
    for (int i = 0; i < 60; i++) begin
      pulse(1 + int'($urandom % 130), 4 + int'($urandom % 12));
    end

    // R6: pin high through reset release
    do_reset(1'b1);
    base = n_valid;
    repeat (3 * N + 10) @(negedge clk);
    pwm_raw = 1'b0;
    repeat (10) @(negedge clk);
    check(n_valid == base, "R6 no strobe for pre-reset pulse", n_valid - base, 0);
    check(inch_out == 0 && overflow == 0, "R6 outputs untouched", inch_out, 0);
    pulse(4 * N + 2, 6);      // R6 next full pulse measured

    // R3: strobe count equals measurements since last reset
    check(n_valid == base + 1, "R3 strobe count", n_valid - base, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule